// File: doc/BRIEF.md
# Isolated Gate-Drive Input Qualifier

This block sits on the logic side of an isolated power-switch gate driver. It decides, once per clock, whether the gate drive may be on. It takes three control pins from a controller: a non-inverting drive input, an inverting drive input and an active-low clear input. It also takes two supply-good flags, one for the logic side and one for the power side, and a latched desaturation-fault flag. Every one of these arrives asynchronously, so each passes through a synchronizer chain. The three control pins then pass through a glitch filter. A change on a filtered pin is accepted only after the synchronized level has held for `FILT_CYC` consecutive clocks.

The block drives two outputs. The first is a single gate-on request. The second is a ready level, which the pad ring turns into an open-drain pin: a low on `ready_o` enables the pull-down. The gate-on request is high only when every condition permits drive. The ready level shows only whether both supplies are good. A power-side supply that is missing or disconnected is reported as a deasserted power-side flag, and the block treats it exactly like an undervoltage.

Top module: `gdrv_in_qual`

## Requirements
- R1: `gate_on_o` is 1 exactly when, after qualification, the non-inverting input is 1, the inverting input is 0, the clear input is 1, both supply flags are 1 and the fault flag is 0.
- R2: While the qualified non-inverting input is 0, `gate_on_o` is 0 whatever the other inputs are.
- R3: While the qualified inverting input is 1, `gate_on_o` is 0 whatever the other inputs are.
- R4: While the qualified clear input is 0, `gate_on_o` is 0, and `ready_o` stays 1 if both supplies are good.
- R5: `ready_o` is 1 exactly when both supply flags are 1. If either flag is 0, both `ready_o` and `gate_on_o` are 0.
- R6: While the fault flag is 1, `gate_on_o` is 0, and `ready_o` is not affected by the fault flag.
- R7: On any of the three control pins, a pulse shorter than `FILT_CYC` clocks has no effect on `gate_on_o`.
- R8: On a control pin, a level held for `FILT_CYC` clocks or longer is accepted. A change on a control pin reaches `gate_on_o` `SYNC_STAGES + FILT_CYC + 1` clocks after it is sampled, and a pulse of exactly `FILT_CYC` clocks produces a gate-on pulse of `FILT_CYC` clocks.
- R9: The supply flags and the fault flag are not filtered. A change on one of them reaches the outputs `SYNC_STAGES + 1` clocks after it is sampled.
- R10: While `rst_n` is low, `gate_on_o` and `ready_o` are 0, whatever the input levels are.
- R11: When a supply flag falls and a control pin's acceptance land in the same clock at the decision logic, `gate_on_o` stays 0. If the supply falls one clock later, the gate-on pulse lasts exactly one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| drv_p_i | input | 1 | Non-inverting drive input (asynchronous) |
| drv_n_i | input | 1 | Inverting drive input (asynchronous) |
| clr_n_i | input | 1 | Active-low clear input (asynchronous) |
| sup_in_ok_i | input | 1 | Logic-side supply-good flag |
| sup_out_ok_i | input | 1 | Power-side supply-good flag; 0 also means the supply is absent |
| fault_i | input | 1 | Latched desaturation-fault flag, active high |
| gate_on_o | output | 1 | Gate-on request |
| ready_o | output | 1 | Supply-ready level; a 0 enables the open-drain pull-down |

## Verification
Two events can meet at the decision register in the same clock: the glitch filter accepting a new drive level, and the supply-good path reporting a drop. The two paths have different latencies, so the bench raises the non-inverting input first and then drops the logic-side supply flag exactly `FILT_CYC` clocks later. With that spacing, both changes reach the decision logic in the same clock. The gate-on output must then stay low for the whole window. The bench repeats the case with the drop one clock later and requires a gate-on pulse of exactly one clock. Around these cases, the bench sweeps all 64 combinations of the six inputs and measures the latency of each path and the width of each pulse.

// File: rtl/gdq_pkg.sv
package gdq_pkg;

   // indices into the synchronized input vector
   localparam int unsigned IDX_DRV_P   = 0;
   localparam int unsigned IDX_DRV_N   = 1;
   localparam int unsigned IDX_CLR_N   = 2;
   localparam int unsigned IDX_SUP_IN  = 3;
   localparam int unsigned IDX_SUP_OUT = 4;
   localparam int unsigned IDX_FAULT   = 5;

   localparam int unsigned N_INPUTS    = 6;
   localparam int unsigned N_FILTERED  = 3;

   // safe (drive-off / not-ready) level of each input, indexed as above
   localparam logic [N_INPUTS-1:0] SAFE_VEC = 6'b100010;

   typedef struct packed {
      logic fault;
      logic sup_out;
      logic sup_in;
      logic clr_n;
      logic drv_n;
      logic drv_p;
   } gdq_qual_t;

   function automatic logic drive_permitted(input gdq_qual_t q);
      return q.drv_p & ~q.drv_n & q.clr_n & q.sup_in & q.sup_out & ~q.fault;
   endfunction

   function automatic logic supplies_ok(input gdq_qual_t q);
      return q.sup_in & q.sup_out;
   endfunction

endpackage

// File: rtl/gdq_sync.sv
module gdq_sync #(
   parameter int unsigned STAGES  = 2,
   parameter logic        RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);

   generate
      if (STAGES < 2) begin : g_bad
         $error("gdq_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain <= {STAGES{RST_VAL}};
      end else begin
         chain <= {chain[STAGES-2:0], d_i};
      end
   end

   assign q_o = chain[STAGES-1];

endmodule

// File: rtl/gdq_deglitch.sv
module gdq_deglitch #(
   parameter int unsigned CYC     = 6,
   parameter logic        RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);

   generate
      if (CYC < 1) begin : g_bad
         $error("gdq_deglitch: CYC must be at least 1");
      end

      if (CYC == 1) begin : g_plain
         // single-sample acceptance: plain register
         logic q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= RST_VAL;
            else        q <= d_i;
         end
         assign q_o = q;
      end else begin : g_count
         localparam int unsigned CW   = $clog2(CYC + 1);
         localparam logic [CW-1:0] LAST = CW'(CYC - 1);

         logic          q;
         logic [CW-1:0] cnt;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               q   <= RST_VAL;
               cnt <= '0;
            end else if (d_i == q) begin
               cnt <= '0;
            end else if (cnt == LAST) begin
               q   <= d_i;
               cnt <= '0;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
         assign q_o = q;
      end
   endgenerate

endmodule

// File: rtl/gdq_gate_logic.sv
module gdq_gate_logic
   import gdq_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  gdq_qual_t qual_i,
   output logic      gate_on_o,
   output logic      ready_o
);

   logic permit;
   logic sup_good;

   always_comb begin
      permit   = drive_permitted(qual_i);
      sup_good = supplies_ok(qual_i);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gate_on_o <= 1'b0;
         ready_o   <= 1'b0;
      end else begin
         gate_on_o <= permit;
         ready_o   <= sup_good;
      end
   end

endmodule

// File: rtl/gdrv_in_qual.sv
module gdrv_in_qual
   import gdq_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned FILT_CYC    = 6
) (
   input  logic clk,
   input  logic rst_n,
   input  logic drv_p_i,
   input  logic drv_n_i,
   input  logic clr_n_i,
   input  logic sup_in_ok_i,
   input  logic sup_out_ok_i,
   input  logic fault_i,
   output logic gate_on_o,
   output logic ready_o
);

   generate
      if (SYNC_STAGES < 2) begin : g_chk_sync
         $error("gdrv_in_qual: SYNC_STAGES below 2");
      end
      if (FILT_CYC < 1) begin : g_chk_filt
         $error("gdrv_in_qual: FILT_CYC below 1");
      end
   endgenerate

   logic [N_INPUTS-1:0]   raw_v;
   logic [N_INPUTS-1:0]   sync_v;
   logic [N_FILTERED-1:0] filt_v;
   gdq_qual_t             qual;

   assign raw_v[IDX_DRV_P]   = drv_p_i;
   assign raw_v[IDX_DRV_N]   = drv_n_i;
   assign raw_v[IDX_CLR_N]   = clr_n_i;
   assign raw_v[IDX_SUP_IN]  = sup_in_ok_i;
   assign raw_v[IDX_SUP_OUT] = sup_out_ok_i;
   assign raw_v[IDX_FAULT]   = fault_i;

   // every input is synchronized; the first N_FILTERED are also deglitched
   generate
      for (genvar i = 0; i < N_INPUTS; i++) begin : g_in
         gdq_sync #(
            .STAGES  (SYNC_STAGES),
            .RST_VAL (SAFE_VEC[i])
         ) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .d_i   (raw_v[i]),
            .q_o   (sync_v[i])
         );
         if (i < N_FILTERED) begin : g_filt
            gdq_deglitch #(
               .CYC     (FILT_CYC),
               .RST_VAL (SAFE_VEC[i])
            ) u_flt (
               .clk   (clk),
               .rst_n (rst_n),
               .d_i   (sync_v[i]),
               .q_o   (filt_v[i])
            );
         end
      end
   endgenerate

   always_comb begin
      qual.drv_p   = filt_v[IDX_DRV_P];
      qual.drv_n   = filt_v[IDX_DRV_N];
      qual.clr_n   = filt_v[IDX_CLR_N];
      qual.sup_in  = sync_v[IDX_SUP_IN];
      qual.sup_out = sync_v[IDX_SUP_OUT];
      qual.fault   = sync_v[IDX_FAULT];
   end

   gdq_gate_logic u_logic (
      .clk       (clk),
      .rst_n     (rst_n),
      .qual_i    (qual),
      .gate_on_o (gate_on_o),
      .ready_o   (ready_o)
   );

endmodule

// File: rtl/gdq_checker.sv
module gdq_checker
   import gdq_pkg::*;
#(
   parameter int unsigned FILT_CYC = 6
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  gate_on_o,
   input logic                  ready_o,
   input logic [N_INPUTS-1:0]   sync_v,
   input logic [N_FILTERED-1:0] filt_v
);

   localparam int unsigned RW = $clog2(FILT_CYC + 1);
   localparam logic [RW-1:0] RMAX = RW'(FILT_CYC);

   // R1: drive is never requested without ready
   a_r1_on_needs_ready: assert property (@(posedge clk) disable iff (!rst_n)
      gate_on_o |-> ready_o);

   // R2
   a_r2_p_low_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      !filt_v[IDX_DRV_P] |=> !gate_on_o);

   // R3
   a_r3_n_high_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      filt_v[IDX_DRV_N] |=> !gate_on_o);

   // R4
   a_r4_clr_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      !filt_v[IDX_CLR_N] |=> !gate_on_o);

   // R5
   a_r5_sup_in_drop: assert property (@(posedge clk) disable iff (!rst_n)
      !sync_v[IDX_SUP_IN] |=> (!ready_o && !gate_on_o));

   a_r5_sup_out_drop: assert property (@(posedge clk) disable iff (!rst_n)
      !sync_v[IDX_SUP_OUT] |=> (!ready_o && !gate_on_o));

   // R6
   a_r6_fault_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      sync_v[IDX_FAULT] |=> !gate_on_o);

   // R7: a filtered level only moves after a long enough stable run
   generate
      for (genvar i = 0; i < N_FILTERED; i++) begin : g_run
         logic          prev;
         logic [RW-1:0] run;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               prev <= SAFE_VEC[i];
               run  <= '0;
            end else begin
               prev <= sync_v[i];
               if (sync_v[i] != prev) run <= RW'(1);
               else if (run != RMAX)  run <= run + 1'b1;
            end
         end

         a_r7_stable_run: assert property (@(posedge clk) disable iff (!rst_n)
            !$stable(filt_v[i]) |-> (run >= RMAX));
      end
   endgenerate

endmodule

bind gdrv_in_qual gdq_checker #(
   .FILT_CYC (FILT_CYC)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .gate_on_o (gate_on_o),
   .ready_o   (ready_o),
   .sync_v    (sync_v),
   .filt_v    (filt_v)
);

// File: tb/gdrv_in_qual_test.sv
module gdrv_in_qual_test;

   localparam int SYNC = 2;
   localparam int FILT = 6;
   localparam int LAT_CTL = SYNC + FILT + 1;
   localparam int LAT_SUP = SYNC + 1;
   localparam int SETTLE  = LAT_CTL + 5;

   logic clk = 1'b0;
   logic rst_n;
   logic drv_p, drv_n, clr_n, sup_in, sup_out, fault;
   logic gate_on, ready;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #2.5 clk = ~clk;

   gdrv_in_qual #(.SYNC_STAGES(SYNC), .FILT_CYC(FILT)) uut (
      .clk          (clk),
      .rst_n        (rst_n),
      .drv_p_i      (drv_p),
      .drv_n_i      (drv_n),
      .clr_n_i      (clr_n),
      .sup_in_ok_i  (sup_in),
      .sup_out_ok_i (sup_out),
      .fault_i      (fault),
      .gate_on_o    (gate_on),
      .ready_o      (ready)
   );

   task automatic chk(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic apply(input logic p, n, c, si, so, f);
      @(negedge clk);
      drv_p = p; drv_n = n; clr_n = c; sup_in = si; sup_out = so; fault = f;
   endtask

   task automatic settle();
      repeat (SETTLE) @(negedge clk);
   endtask

   // count negedges at which gate_on is high over a window
   task automatic watch(input int cycles, output int highs);
      highs = 0;
      for (int k = 0; k < cycles; k++) begin
         @(negedge clk);
         if (gate_on) highs++;
      end
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      int h;
      int k;
      logic [5:0] v;
      logic exp_g, exp_r;

      // R10: reset holds outputs off even with all-permit inputs
      rst_n = 1'b0;
      drv_p = 1; drv_n = 0; clr_n = 1; sup_in = 1; sup_out = 1; fault = 0;
      repeat (5) @(negedge clk);
      chk("R10 gate during reset", gate_on, 0);
      chk("R10 ready during reset", ready, 0);
      rst_n = 1'b1;
      settle();
      chk("R1 all permit", gate_on, 1);

      // R1/R5: exhaustive sweep of the six inputs
      for (int i = 0; i < 64; i++) begin
         v = 6'(i);
         apply(v[0], v[1], v[2], v[3], v[4], v[5]);
         settle();
         exp_g = v[0] & ~v[1] & v[2] & v[3] & v[4] & ~v[5];
         exp_r = v[3] & v[4];
         chk($sformatf("R1 sweep %0d", i), gate_on, exp_g);
         chk($sformatf("R5 sweep %0d", i), ready, exp_r);
      end

      // R2, R3, R4, R6 single-condition blocks
      apply(0, 0, 1, 1, 1, 0); settle();
      chk("R2 p low", gate_on, 0);
      apply(1, 1, 1, 1, 1, 0); settle();
      chk("R3 n high", gate_on, 0);
      apply(1, 0, 0, 1, 1, 0); settle();
      chk("R4 clear low gate", gate_on, 0);
      chk("R4 clear low ready", ready, 1);
      apply(1, 0, 1, 1, 1, 1); settle();
      chk("R6 fault gate", gate_on, 0);
      chk("R6 fault ready", ready, 1);
      apply(1, 0, 1, 1, 0, 0); settle();
      chk("R5 out supply absent gate", gate_on, 0);
      chk("R5 out supply absent ready", ready, 0);

      // R8: latency of control path
      apply(0, 0, 1, 1, 1, 0); settle();
      @(negedge clk); drv_p = 1;
      k = 0;
      do begin @(negedge clk); k++; end while (!gate_on && k < 40);
      chk("R8 control latency", k, LAT_CTL);

      // R9: supply and fault latency
      @(negedge clk); sup_in = 0;
      k = 0;
      do begin @(negedge clk); k++; end while (ready && k < 40);
      chk("R9 supply latency", k, LAT_SUP);
      @(negedge clk); sup_in = 1; settle();
      @(negedge clk); fault = 1;
      k = 0;
      do begin @(negedge clk); k++; end while (gate_on && k < 40);
      chk("R9 fault latency", k, LAT_SUP);
      @(negedge clk); fault = 0; settle();

      // R7: short pulses rejected on each control pin
      apply(0, 0, 1, 1, 1, 0); settle();
      @(negedge clk); drv_p = 1;
      repeat (FILT - 1) @(negedge clk);
      drv_p = 0;
      watch(3 * LAT_CTL, h);
      chk("R7 short p pulse", h, 0);

      apply(1, 0, 1, 1, 1, 0); settle();
      @(negedge clk); drv_n = 1;
      repeat (FILT - 1) @(negedge clk);
      drv_n = 0;
      watch(3 * LAT_CTL, h);
      chk("R7 short n pulse", h, 3 * LAT_CTL);

      @(negedge clk); clr_n = 0;
      repeat (FILT - 1) @(negedge clk);
      clr_n = 1;
      watch(3 * LAT_CTL, h);
      chk("R7 short clear pulse", h, 3 * LAT_CTL);

      // R8: pulse of exactly FILT passes with FILT width
      apply(0, 0, 1, 1, 1, 0); settle();
      @(negedge clk); drv_p = 1;
      repeat (FILT) @(negedge clk);
      drv_p = 0;
      watch(3 * LAT_CTL, h);
      chk("R8 min pulse width", h, FILT);

      // R11: acceptance and supply drop meet in one cycle
      apply(0, 0, 1, 1, 1, 0); settle();
      @(negedge clk); drv_p = 1;
      repeat (FILT) @(negedge clk);
      sup_in = 0;
      watch(3 * LAT_CTL, h);
      chk("R11 coincident drop", h, 0);
      chk("R11 ready low", ready, 0);

      apply(0, 0, 1, 1, 1, 0); settle();
      @(negedge clk); drv_p = 1;
      repeat (FILT + 1) @(negedge clk);
      sup_in = 0;
      watch(3 * LAT_CTL, h);
      chk("R11 drop one later", h, 1);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule